// File: doc/BRIEF.md
# Burst Checkword Generator and Checker

This block protects bursts of 32-bit words on a parallel data channel with a per-burst checkword. The checkword is the even parity of each bit column across the burst. The burst word count, modulo 256, is folded into the low byte of that parity. The block also generates and checks odd parity for each data byte.

The transmit side accumulates every accepted word of a burst. In the cycle right after the word marked as last, it presents the finished checkword for one cycle. Short bursts are handled the same way as full ones. The receive side accumulates incoming words in the same way. When the received checkword is presented, it compares it against its own result and pulses a mismatch flag. It also keeps a sticky flag that records byte-parity errors seen in the current burst.

A burst is the span during which the burst strobe of a side is high. A word is accepted only when both the valid strobe and the burst strobe are high. Both sides restart their accumulation when their burst strobe rises.

Top module: `burst_check_unit`

## Requirements
- R1: `tx_par[i]` is the odd-parity bit of byte lane i, which is `tx_data[8i+7:8i]`. The byte and its bit together hold an odd number of ones. The output follows `tx_data` in the same cycle.
- R2: Bit b of a checkword is the XOR of bit b over all words accepted in the burst, before the count is folded in.
- R3: The low 8 bits of the checkword are additionally XORed with the number of accepted words modulo 256. A 256-word burst folds in zero, and a 1-word burst folds in 1.
- R4: `tx_ckw_valid` is high for exactly one cycle, the cycle after an accepted word with `tx_last` high, and `tx_ckw` holds the checkword for that burst in that cycle.
- R5: Accumulation and word count restart at a rising edge of the burst strobe, and the word taken in that same cycle is the first word counted. Words with valid low, or presented while the burst strobe is low, have no effect on the checkword.
- R6: `rx_ckw_err` is high for one cycle, the cycle after `rx_ckw_valid` is high, exactly when `rx_ckw` differs from the checkword of the words accepted so far in the burst. It is low otherwise.
- R7: An accepted receive word whose byte lane i together with `rx_par[i]` has an even number of ones sets `rx_par_err` in the next cycle. The flag stays set after the burst ends.
- R8: `rx_par_err` clears when the next receive burst starts. If the first word of that burst has a parity error, the set wins and the flag stays high.
- R9: After reset, `tx_ckw_valid`, `tx_ckw`, `rx_ckw_err` and `rx_par_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_burst | input | 1 | Transmit burst strobe |
| tx_valid | input | 1 | Transmit word valid |
| tx_last | input | 1 | Marks the final transmit word of the burst |
| tx_data | input | 32 | Transmit word |
| tx_par | output | 4 | Odd byte parity of `tx_data` |
| tx_ckw_valid | output | 1 | Checkword present on `tx_ckw` |
| tx_ckw | output | 32 | Generated checkword |
| rx_burst | input | 1 | Receive burst strobe |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Received word |
| rx_par | input | 4 | Received byte parity |
| rx_ckw_valid | input | 1 | Received checkword present on `rx_ckw` |
| rx_ckw | input | 32 | Received checkword |
| rx_ckw_err | output | 1 | Checkword mismatch pulse |
| rx_par_err | output | 1 | Sticky byte-parity error flag |

## Verification
The sticky parity flag has two updates that can fall in the same cycle: the clear at the start of a burst and the set caused by a bad word. The bench provokes this collision with a burst whose first word carries a corrupted parity bit, sent right after a burst that had already set the flag. In that case the flag must stay high through the first word. A following burst that opens with a clean word must then drop the flag, which shows the clear still works when no set competes with it.

// File: rtl/ckw_pkg.sv
package ckw_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int CNT_W  = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Column parity with the word count merged into the low bits.
  function automatic word_t fold_count(word_t acc, cnt_t cnt);
    return acc ^ word_t'(cnt);
  endfunction

  // Bit that makes a lane hold an odd number of ones.
  function automatic logic lane_odd_bit(logic [LANE_W-1:0] lane);
    return ~(^lane);
  endfunction
endpackage

// File: rtl/parity_lanes.sv
module parity_lanes
  import ckw_pkg::*;
(
  input  word_t data,
  output lane_t par_gen
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par_gen[i] = lane_odd_bit(data[i*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/ckw_accum.sv
module ckw_accum
  import ckw_pkg::*;
#(
  parameter bit LOOKAHEAD = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  burst,
  input  logic  valid,
  input  word_t data,
  output logic  start_o,
  output logic  take_o,
  output word_t ckw_o
);
  logic  burst_q;
  word_t acc_q, acc_base, acc_d;
  cnt_t  cnt_q, cnt_base, cnt_d;

  assign start_o = burst & ~burst_q;
  assign take_o  = burst & valid;

  always_comb begin
    acc_base = start_o ? '0 : acc_q;
    cnt_base = start_o ? '0 : cnt_q;
    acc_d    = take_o ? (acc_base ^ data) : acc_base;
    cnt_d    = take_o ? (cnt_base + cnt_t'(1)) : cnt_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else begin
      burst_q <= burst;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
    end
  end

  if (LOOKAHEAD) begin : g_ahead
    assign ckw_o = fold_count(acc_d, cnt_d);
  end else begin : g_now
    assign ckw_o = fold_count(acc_q, cnt_q);
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !take_o) |=> (acc_q == '0 && cnt_q == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_o && !start_o) |=> ($stable(acc_q) && $stable(cnt_q))); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !start_o) |=> (cnt_q == $past(cnt_q) + cnt_t'(1))); // R3
endmodule

// File: rtl/ckw_tx.sv
module ckw_tx
  import ckw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  burst,
  input  logic  valid,
  input  logic  last,
  input  word_t data,
  output lane_t par,
  output logic  ckw_valid,
  output word_t ckw
);
  logic  start, take, emit;
  word_t ckw_ahead;

  ckw_accum #(.LOOKAHEAD(1'b1)) u_acc (
    .clk(clk), .rst_n(rst_n), .burst(burst), .valid(valid), .data(data),
    .start_o(start), .take_o(take), .ckw_o(ckw_ahead)
  );

  parity_lanes u_par (.data(data), .par_gen(par));

  assign emit = take & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ckw_valid <= 1'b0;
      ckw       <= '0;
    end else begin
      ckw_valid <= emit;
      if (emit) ckw <= ckw_ahead;
    end
  end

  AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> ckw_valid); // R4
  AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ckw_valid |-> $past(emit)); // R4
  AST_START_NOT_EMIT_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !take) |=> !ckw_valid); // R5
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_TX_LANE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({data[i*LANE_W +: LANE_W], par[i]}) % 2) == 1); // R1
  end
endmodule

// File: rtl/ckw_rx.sv
module ckw_rx
  import ckw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  burst,
  input  logic  valid,
  input  word_t data,
  input  lane_t par,
  input  logic  ckw_valid,
  input  word_t ckw_in,
  output logic  ckw_err,
  output logic  par_err
);
  logic  start, take, word_bad;
  word_t ckw_local;
  lane_t par_exp;

  ckw_accum #(.LOOKAHEAD(1'b0)) u_acc (
    .clk(clk), .rst_n(rst_n), .burst(burst), .valid(valid), .data(data),
    .start_o(start), .take_o(take), .ckw_o(ckw_local)
  );

  parity_lanes u_par (.data(data), .par_gen(par_exp));

  assign word_bad = take & (|(par_exp ^ par));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ckw_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      ckw_err <= ckw_valid && (ckw_in != ckw_local);
      if (word_bad)   par_err <= 1'b1;
      else if (start) par_err <= 1'b0;
    end
  end

  AST_ERR_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    ckw_err |-> $past(ckw_valid)); // R6
  AST_PERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |=> par_err); // R7
  AST_PERR_FALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_err) |-> $past(start)); // R8
endmodule

// File: rtl/burst_check_unit.sv
module burst_check_unit
  import ckw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_burst,
  input  logic        tx_valid,
  input  logic        tx_last,
  input  logic [31:0] tx_data,
  output logic [3:0]  tx_par,
  output logic        tx_ckw_valid,
  output logic [31:0] tx_ckw,
  input  logic        rx_burst,
  input  logic        rx_valid,
  input  logic [31:0] rx_data,
  input  logic [3:0]  rx_par,
  input  logic        rx_ckw_valid,
  input  logic [31:0] rx_ckw,
  output logic        rx_ckw_err,
  output logic        rx_par_err
);
  ckw_tx u_tx (
    .clk(clk), .rst_n(rst_n), .burst(tx_burst), .valid(tx_valid),
    .last(tx_last), .data(tx_data), .par(tx_par),
    .ckw_valid(tx_ckw_valid), .ckw(tx_ckw)
  );

  ckw_rx u_rx (
    .clk(clk), .rst_n(rst_n), .burst(rx_burst), .valid(rx_valid),
    .data(rx_data), .par(rx_par), .ckw_valid(rx_ckw_valid),
    .ckw_in(rx_ckw), .ckw_err(rx_ckw_err), .par_err(rx_par_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!tx_ckw_valid && !rx_ckw_err && !rx_par_err)); // R9
endmodule

// File: tb/tb_burst_check_unit.sv
module tb_burst_check_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_burst, tx_valid, tx_last;
  logic [31:0] tx_data;
  logic [3:0]  tx_par;
  logic        tx_ckw_valid;
  logic [31:0] tx_ckw;
  logic        rx_burst, rx_valid, rx_ckw_valid;
  logic [31:0] rx_data, rx_ckw;
  logic [3:0]  rx_par;
  logic        rx_ckw_err, rx_par_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [31:0] kept [0:255];
  logic        exp_perr;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_check_unit dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int seed, input int i);
    return (32'(seed) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 13);
  endfunction

  function automatic logic [3:0] odd_par(input logic [31:0] w);
    logic [3:0] p;
    for (int l = 0; l < 4; l++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(w[l*8+b]);
      p[l] = (ones % 2 == 0);
    end
    return p;
  endfunction

  // Column-by-column ones count over kept[0..n-1], with count bits added to the low byte.
  function automatic logic [31:0] model_ckw(input int n);
    logic [31:0] r;
    logic [7:0]  c = 8'(n);
    for (int b = 0; b < 32; b++) begin
      int ones = 0;
      for (int k = 0; k < n; k++) ones += int'(kept[k][b]);
      if (b < 8) ones += int'(c[b]);
      r[b] = ones[0];
    end
    return r;
  endfunction

  task automatic idle_inputs();
    tx_burst = 0; tx_valid = 0; tx_last = 0; tx_data = '0;
    rx_burst = 0; rx_valid = 0; rx_ckw_valid = 0; rx_ckw = '0; rx_data = '0; rx_par = '0;
  endtask

  task automatic tx_send(input int n, input int seed, input string req);
    logic [31:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) check(tx_ckw_valid == 1'b0, "R4 no early ckw", 32'(tx_ckw_valid), 0);
      tx_burst = 1; tx_valid = 1; tx_data = word_at(seed, i); tx_last = (i == n-1);
      kept[i] = tx_data;
      #1 if (i < 3) check(tx_par == odd_par(tx_data), "R1 tx lane parity", 32'(tx_par), 32'(odd_par(tx_data)));
    end
    @(negedge clk);
    e = model_ckw(n);
    check(tx_ckw_valid == 1'b1, {req, " ckw valid"}, 32'(tx_ckw_valid), 1);
    check(tx_ckw == e, {req, " ckw value"}, tx_ckw, e);
    tx_burst = 0; tx_valid = 0; tx_last = 0;
    @(negedge clk);
    check(tx_ckw_valid == 1'b0, "R4 one-cycle ckw", 32'(tx_ckw_valid), 0);
  endtask

  // bad_idx: word with flipped parity (-1 none); mask: corruption applied to sent checkword.
  task automatic rx_send(input int n, input int seed, input int bad_idx, input logic [31:0] mask, input string req);
    logic [31:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) check(rx_par_err == exp_perr, "R7 sticky parity flag", 32'(rx_par_err), 32'(exp_perr));
      rx_burst = 1; rx_valid = 1; rx_data = word_at(seed, i);
      rx_par = odd_par(rx_data) ^ ((i == bad_idx) ? 4'b0100 : 4'b0000);
      kept[i] = rx_data;
      if (i == 0) exp_perr = 0;
      if (i == bad_idx) exp_perr = 1;
    end
    @(negedge clk);
    check(rx_par_err == exp_perr, {req, " parity flag at end"}, 32'(rx_par_err), 32'(exp_perr));
    e = model_ckw(n);
    rx_burst = 0; rx_valid = 0; rx_ckw_valid = 1; rx_ckw = e ^ mask;
    @(negedge clk);
    check(rx_ckw_err == (mask != 0), {req, " mismatch pulse"}, 32'(rx_ckw_err), 32'(mask != 0));
    rx_ckw_valid = 0;
    @(negedge clk);
    check(rx_ckw_err == 1'b0, "R6 pulse one cycle", 32'(rx_ckw_err), 0);
    check(rx_par_err == exp_perr, "R7 flag held after burst", 32'(rx_par_err), 32'(exp_perr));
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!tx_ckw_valid && tx_ckw == '0, "R9 tx reset", tx_ckw, 0);
    check(!rx_ckw_err && !rx_par_err, "R9 rx reset", 32'({rx_ckw_err, rx_par_err}), 0);
    exp_perr = 0;
  endtask

  task automatic t_tx_gaps();
    int k = 0;
    logic [31:0] e;
    // Words outside the burst must be ignored (R5), including a marked last.
    @(negedge clk);
    tx_burst = 0; tx_valid = 1; tx_last = 1; tx_data = 32'hDEAD_BEEF;
    @(negedge clk);
    tx_valid = 0; tx_last = 0;
    check(tx_ckw_valid == 1'b0, "R5 word outside burst ignored", 32'(tx_ckw_valid), 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      tx_burst = 1; tx_valid = (i % 2 == 0); tx_data = word_at(77, i); tx_last = (i == 6);
      if (tx_valid) begin kept[k] = tx_data; k++; end
    end
    @(negedge clk);
    e = model_ckw(k);
    check(tx_ckw == e && tx_ckw_valid, "R5 invalid gap words ignored", tx_ckw, e);
    tx_burst = 0; tx_valid = 0; tx_last = 0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    tx_send(5,   11, "R2");
    tx_send(1,   12, "R3 single word");
    tx_send(256, 13, "R3 full burst count zero");
    tx_send(3,   14, "R5 restart after long burst");
    t_tx_gaps();
    rx_send(6,   21, -1, 32'h0, "R6 good ckw");
    rx_send(4,   22, -1, 32'h0000_0100, "R6 bad ckw");
    rx_send(256, 23, -1, 32'h0, "R6 full burst good");
    rx_send(5,   24,  2, 32'h0, "R7 parity error");
    rx_send(3,   25,  0, 32'h0, "R8 first-word error keeps flag");
    rx_send(3,   26, -1, 32'h8000_0000, "R8 clean burst clears flag");
    check(rx_par_err == 1'b0, "R8 cleared", 32'(rx_par_err), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule